// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block sits beside an SDRAM command bus and follows the device-level state of a single bank from the pins alone. On every rising clock edge it decodes chip select, row strobe, column strobe, write enable, clock enable, A10 and the bank address into a command. It then decides whether that command is allowed in the state the device is in, and it advances its own copy of the device state.

The tracked states are idle, bank active, precharging, auto-refresh, mode-register programming, self-refresh and power-down. Precharging, auto-refresh and mode-register programming each last a fixed number of clock cycles, set by parameters, and then fall back to idle without any further command. Self-refresh and power-down are held for as long as clock enable stays low.

All outputs are registered. They are a one-cycle flag for each illegal command, the decoded command code and the current state code. A monitor or a controller self-check can use them to catch protocol violations as they happen.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted, and until the first command edge after release, `state_o` is 0 (idle), `illegal_o` is 0 and `cmd_o` is 0 (deselect).
- R2: `cmd_o` gives the command sampled at an edge, coded as follows. cs_n=1 gives 0, deselect. For the rest, the (ras_n,cas_n,we_n) values map as: 111 gives 1, no-op; 110 gives 2, burst stop; 101 gives 3, read; 100 gives 4, write; 011 gives 5, activate; 010 gives 6, single precharge when a10=0, or 7, precharge-all when a10=1; 001 gives 8, auto-refresh when cke=1, or 9, self-refresh when cke=0; 000 gives 10, mode-register set.
- R3: In idle (state 0) with cke=1, activate moves to bank active (state 1) and stores `ba` as the open bank. Read and write raise `illegal_o` and leave the state at idle. Deselect, no-op, burst stop, precharge and precharge-all raise no flag and leave the state at idle.
- R4: In idle with cke=1, auto-refresh moves to state 3 and mode-register set moves to state 4. These states last exactly T_RFC and T_MRD cycles, then return to idle.
- R5: In bank active, precharge-all, or a single precharge whose `ba` equals the open bank, moves to precharging (state 2). A single precharge to any other bank raises no flag and stays in bank active. Read, write, burst stop, no-op and deselect raise no flag. Activate, auto-refresh, self-refresh and mode-register set raise `illegal_o` and leave the state unchanged.
- R6: Precharging lasts exactly T_RP cycles, whatever commands arrive, and then returns to idle. In this state, read, write, activate, auto-refresh, self-refresh and mode-register set raise `illegal_o`. Burst stop, precharge, precharge-all, no-op and deselect raise no flag.
- R7: In the auto-refresh and mode-register states, any command other than deselect or no-op raises `illegal_o`. Such a command does not change the length of the state.
- R8: In idle, the self-refresh command (code 9) enters self-refresh (state 5). The state holds while cke=0, no command raises a flag, and the first edge with cke=1 returns to idle.
- R9: In idle, cke=0 with any command other than self-refresh enters power-down (state 6), with no flag even for read or write. The state holds while cke=0 with no flags, and the first edge with cke=1 returns to idle.
- R10: `illegal_o` and `cmd_o` describe the command sampled at the most recent edge and last exactly one cycle. A legal command that follows an illegal one clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Address bit 10, picks single or all-bank precharge |
| ba | input | BA_W | Bank address |
| illegal_o | output | 1 | One-cycle flag for an illegal command |
| cmd_o | output | 4 | Decoded command code (R2) |
| state_o | output | 3 | Tracked state code |

## Verification
The bench builds the tracker with T_RP=4, T_RFC=6, T_MRD=2 and BA_W=2. The three durations are short enough that the bench can walk every cycle of each timed state and check the exact exit edge. Because the values differ, a state that exits on the wrong duration is caught. Two bank-address bits allow a single precharge to a bank other than the open one, so the bench can check the case that must leave bank active unchanged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_PALL  = 4'd7,
    CMD_REF   = 4'd8,
    CMD_SELF  = 4'd9,
    CMD_MRS   = 4'd10
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACT  = 3'd1,
    ST_PRE  = 3'd2,
    ST_REFR = 3'd3,
    ST_MRS  = 3'd4,
    ST_SELF = 3'd5,
    ST_PD   = 3'd6
  } sd_state_e;
endpackage

// File: rtl/sdcmd_rst_sync.sv
module sdcmd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ln = sync_q;
endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    cke,
  input  logic    a10,
  output sd_cmd_e cmd
);
  always_comb begin
    cmd = CMD_DESL;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b110: cmd = CMD_BST;
        3'b101: cmd = CMD_READ;
        3'b100: cmd = CMD_WRITE;
        3'b011: cmd = CMD_ACT;
        3'b010: cmd = a10 ? CMD_PALL : CMD_PRE;
        3'b001: cmd = cke ? CMD_REF : CMD_SELF;
        default: cmd = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
  import sdcmd_pkg::*;
(
  input  sd_state_e state,
  input  sd_cmd_e   cmd,
  input  logic      cke,
  output logic      illegal
);
  logic is_rw;
  logic is_rowop;
  logic is_idle_cmd;

  always_comb begin
    is_rw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    is_rowop    = (cmd == CMD_ACT) || (cmd == CMD_REF) ||
                  (cmd == CMD_SELF) || (cmd == CMD_MRS);
    is_idle_cmd = (cmd == CMD_DESL) || (cmd == CMD_NOP);
  end

  always_comb begin
    illegal = 1'b0;
    unique case (state)
      ST_IDLE:         illegal = cke && is_rw;
      ST_ACT:          illegal = is_rowop;
      ST_PRE:          illegal = is_rw || is_rowop;
      ST_REFR, ST_MRS: illegal = !is_idle_cmd;
      default:         illegal = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R6
  timer_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RP  = 3,
  parameter int T_RFC = 7,
  parameter int T_MRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic            a10,
  input  logic [BA_W-1:0] ba,
  output logic            illegal_o,
  output logic [3:0]      cmd_o,
  output logic [2:0]      state_o
);
  localparam int T_MAX0 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_MAX  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
  localparam int CNT_W  = (T_MAX < 2) ? 1 : $clog2(T_MAX);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);

  logic             rst_ln;
  sd_cmd_e          cmd;
  logic             illegal;
  logic             t_done;
  logic             t_load;
  logic [CNT_W-1:0] t_val;

  sd_state_e        state_q, state_d;
  sd_cmd_e          cmd_q;
  logic             illegal_q;
  logic [BA_W-1:0]  bank_q;
  logic             bank_en;
  logic             bank_hit;

  sdcmd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_ln)
  );

  sdcmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .a10   (a10),
    .cmd   (cmd)
  );

  sdcmd_rules u_rules (
    .state   (state_q),
    .cmd     (cmd),
    .cke     (cke),
    .illegal (illegal)
  );

  sdcmd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_ln),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  assign bank_hit = (ba == bank_q);

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = RP_LD;
    bank_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd == CMD_SELF) begin
          state_d = ST_SELF;
        end else if (!cke) begin
          state_d = ST_PD;
        end else begin
          unique case (cmd)
            CMD_ACT: begin
              state_d = ST_ACT;
              bank_en = 1'b1;
            end
            CMD_REF: begin
              state_d = ST_REFR;
              t_load  = 1'b1;
              t_val   = RFC_LD;
            end
            CMD_MRS: begin
              state_d = ST_MRS;
              t_load  = 1'b1;
              t_val   = MRD_LD;
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_ACT: begin
        if ((cmd == CMD_PALL) || ((cmd == CMD_PRE) && bank_hit)) begin
          state_d = ST_PRE;
          t_load  = 1'b1;
          t_val   = RP_LD;
        end
      end
      ST_PRE, ST_REFR, ST_MRS: begin
        if (t_done) state_d = ST_IDLE;
      end
      ST_SELF, ST_PD: begin
        if (cke) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q   <= ST_IDLE;
      cmd_q     <= CMD_DESL;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd;
      illegal_q <= illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)      bank_q <= '0;
    else if (bank_en) bank_q <= ba;
  end

  assign illegal_o = illegal_q;
  assign cmd_o     = cmd_q;
  assign state_o   = state_q;

  // R6
  pre_exit_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_PRE) |=> (state_q == ST_PRE || state_q == ST_IDLE));

  // R8
  self_exit_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_SELF) |=> (state_q == ST_SELF || state_q == ST_IDLE));

  // R9
  lowpower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_SELF || state_q == ST_PD) |=> !illegal_q);

  // R5
  act_entry_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q != ST_IDLE && state_q != ST_ACT) |=> (state_q != ST_ACT));

  // R4
  refr_exit_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_REFR) |=> (state_q == ST_REFR || state_q == ST_IDLE));
endmodule

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;
  localparam int BA_W  = 2;
  localparam int T_RP  = 4;
  localparam int T_RFC = 6;
  localparam int T_MRD = 2;

  localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4, C_ACT = 5;
  localparam int C_PRE = 6, C_PALL = 7, C_REF = 8, C_SELF = 9, C_MRS = 10;
  localparam int S_IDLE = 0, S_ACT = 1, S_PRE = 2, S_REFR = 3, S_MRS = 4, S_SELF = 5, S_PD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [BA_W-1:0] ba = '0;
  logic illegal_o;
  logic [3:0] cmd_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_cmd_tracker #(.BA_W(BA_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .a10(a10), .ba(ba), .illegal_o(illegal_o), .cmd_o(cmd_o), .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int st, input int ill, input int cd);
    chk({tag, " state"}, int'(state_o), st);
    chk({tag, " illegal"}, int'(illegal_o), ill);
    chk({tag, " cmd"}, int'(cmd_o), cd);
  endtask

  task automatic issue(input int code, input logic ke, input logic [BA_W-1:0] b);
    @(negedge clk);
    cke = ke;
    ba  = b;
    a10 = 1'b0;
    cs_n = 1'b0;
    case (code)
      C_DESL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
      C_NOP:  {ras_n, cas_n, we_n} = 3'b111;
      C_BST:  {ras_n, cas_n, we_n} = 3'b110;
      C_RD:   {ras_n, cas_n, we_n} = 3'b101;
      C_WR:   {ras_n, cas_n, we_n} = 3'b100;
      C_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      C_PRE:  {ras_n, cas_n, we_n} = 3'b010;
      C_PALL: begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      C_REF, C_SELF: {ras_n, cas_n, we_n} = 3'b001;
      default: {ras_n, cas_n, we_n} = 3'b000;
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 in reset", S_IDLE, 0, C_DESL);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 after release", S_IDLE, 0, C_DESL);
  endtask

  task automatic t_idle();
    issue(C_DESL, 1, 0); expect_out("R2 R3 idle desl", S_IDLE, 0, C_DESL);
    issue(C_NOP, 1, 0);  expect_out("R2 R3 idle nop", S_IDLE, 0, C_NOP);
    issue(C_BST, 1, 0);  expect_out("R2 R3 idle bst", S_IDLE, 0, C_BST);
    issue(C_RD, 1, 0);   expect_out("R2 R3 idle read", S_IDLE, 1, C_RD);
    issue(C_WR, 1, 0);   expect_out("R2 R3 idle write", S_IDLE, 1, C_WR);
    issue(C_PRE, 1, 0);  expect_out("R2 R3 idle pre", S_IDLE, 0, C_PRE);
    issue(C_PALL, 1, 0); expect_out("R2 R3 idle pall", S_IDLE, 0, C_PALL);
  endtask

  task automatic t_refresh();
    issue(C_REF, 1, 0); expect_out("R4 ref entry", S_REFR, 0, C_REF);
    for (int i = 1; i < T_RFC; i++) begin
      if (i == 2) begin
        issue(C_RD, 1, 0); expect_out("R7 read in refresh", S_REFR, 1, C_RD);
      end else begin
        issue(C_NOP, 1, 0); expect_out("R4 refresh hold", S_REFR, 0, C_NOP);
      end
    end
    issue(C_NOP, 1, 0); expect_out("R4 refresh exit", S_IDLE, 0, C_NOP);
  endtask

  task automatic t_mrs();
    issue(C_MRS, 1, 0); expect_out("R2 R4 mrs entry", S_MRS, 0, C_MRS);
    issue(C_ACT, 1, 0); expect_out("R7 act in mrs", S_MRS, 1, C_ACT);
    issue(C_NOP, 1, 0); expect_out("R4 mrs exit", S_IDLE, 0, C_NOP);
  endtask

  task automatic t_active();
    issue(C_ACT, 1, 2'd1); expect_out("R3 activate", S_ACT, 0, C_ACT);
    issue(C_RD, 1, 2'd1);  expect_out("R5 read active", S_ACT, 0, C_RD);
    issue(C_WR, 1, 2'd1);  expect_out("R5 write active", S_ACT, 0, C_WR);
    issue(C_BST, 1, 2'd1); expect_out("R5 bst active", S_ACT, 0, C_BST);
    issue(C_ACT, 1, 2'd1); expect_out("R5 act in active", S_ACT, 1, C_ACT);
    issue(C_NOP, 1, 2'd1); expect_out("R10 flag clears", S_ACT, 0, C_NOP);
    issue(C_REF, 1, 2'd1); expect_out("R5 ref in active", S_ACT, 1, C_REF);
    issue(C_MRS, 1, 2'd1); expect_out("R5 mrs in active", S_ACT, 1, C_MRS);
    issue(C_PRE, 1, 2'd2); expect_out("R5 pre other bank", S_ACT, 0, C_PRE);
    issue(C_PRE, 1, 2'd1); expect_out("R5 pre open bank", S_PRE, 0, C_PRE);
    issue(C_RD, 1, 0);     expect_out("R6 read in pre", S_PRE, 1, C_RD);
    issue(C_ACT, 1, 0);    expect_out("R6 act in pre", S_PRE, 1, C_ACT);
    issue(C_PALL, 1, 0);   expect_out("R6 pall in pre", S_PRE, 0, C_PALL);
    issue(C_NOP, 1, 0);    expect_out("R6 pre exit", S_IDLE, 0, C_NOP);
    issue(C_ACT, 1, 2'd0); expect_out("R3 activate bank0", S_ACT, 0, C_ACT);
    issue(C_PALL, 1, 2'd3); expect_out("R5 pall", S_PRE, 0, C_PALL);
    for (int i = 1; i < T_RP; i++) begin
      issue(C_BST, 1, 0); expect_out("R6 pre hold", S_PRE, 0, C_BST);
    end
    issue(C_DESL, 1, 0); expect_out("R6 pall exit", S_IDLE, 0, C_DESL);
  endtask

  task automatic t_self();
    issue(C_SELF, 0, 0); expect_out("R2 R8 self entry", S_SELF, 0, C_SELF);
    issue(C_RD, 0, 0);   expect_out("R8 read in self", S_SELF, 0, C_RD);
    issue(C_NOP, 0, 0);  expect_out("R8 self hold", S_SELF, 0, C_NOP);
    issue(C_NOP, 1, 0);  expect_out("R8 self exit", S_IDLE, 0, C_NOP);
  endtask

  task automatic t_pdown();
    issue(C_RD, 0, 0);   expect_out("R9 pd entry on read", S_PD, 0, C_RD);
    issue(C_WR, 0, 0);   expect_out("R9 write in pd", S_PD, 0, C_WR);
    issue(C_NOP, 1, 0);  expect_out("R9 pd exit", S_IDLE, 0, C_NOP);
    issue(C_NOP, 0, 0);  expect_out("R9 pd entry nop", S_PD, 0, C_NOP);
    issue(C_DESL, 1, 0); expect_out("R9 pd exit desl", S_IDLE, 0, C_DESL);
  endtask

  task automatic t_pulse();
    issue(C_WR, 1, 0);   expect_out("R10 pulse high", S_IDLE, 1, C_WR);
    issue(C_DESL, 1, 0); expect_out("R10 pulse low", S_IDLE, 0, C_DESL);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_refresh();
    t_mrs();
    t_active();
    t_self();
    t_pdown();
    t_pulse();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule